// File: doc/BRIEF.md
# Robust I2C Target Controller

This block is an I2C target (slave) with a fixed 7-bit address. It takes the raw SCL and SDA pins and passes each through a two-flop synchroniser and a short glitch filter. It watches the filtered lines for START and STOP conditions. It answers to its own address and moves bytes in both directions. It drives SDA only through an open-drain enable. On the user side there are three things: a one-cycle strobe carrying each received byte, a one-cycle request for the next byte to transmit, and a busy flag.

The control logic does not trust the bus to stay in step. Any START edge puts it back at the start of the address phase, whatever it was doing. This covers a START that lands in the middle of a byte and a START that arrives straight after a read-direction address acknowledge. STOP returns the block to idle. An inactivity counter also returns it to idle if SCL stops moving while a transfer is open. A NACK on its own never brings the block back to idle.

Top module: `robust_i2c_target`

## Requirements
- R1: After reset, `sda_oe_o`, `busy_o`, `wr_valid_o` and `rd_req_o` are all 0.
- R2: The first byte after a START is shifted in MSB first. Bits 7..1 are the address and bit 0 is the direction (1 = read). The block drives SDA low during the ninth clock only when bits 7..1 equal `OWN_ADDR`. With any other address it drives nothing and reports nothing until the next START.
- R3: In a write transfer, each data byte is presented on `wr_data_o` together with a one-cycle `wr_valid_o` pulse once its eighth bit is in. The block acknowledges every written byte.
- R4: In a read transfer, `rd_req_o` pulses once before each byte: after the address acknowledge, and after each master ACK. `rd_data_i` must be valid in the cycle after the pulse. Bits go out MSB first.
- R5: When the master NACKs a read byte, SDA is released, no further `rd_req_o` pulse is made, and `busy_o` stays 1 until a STOP or a START.
- R6: A START (SDA falling while SCL is high) seen at any bit position aborts the current byte. That byte is never delivered, and the address phase begins again.
- R7: A repeated START that follows a read-direction address acknowledge, with no data byte clocked in between, is accepted. The next address byte is matched, acknowledged and served normally.
- R8: A STOP (SDA rising while SCL is high) at any point returns the block to idle with SDA released.
- R9: If the filtered SCL shows no edge for `TIMEOUT_CYC` system clocks while `busy_o` is 1, the block releases SDA and returns to idle.
- R10: `sda_oe_o` only goes from 0 to 1 while SCL is low.
- R11: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |
| wr_valid_o | output | 1 | One-cycle strobe: a received byte is on `wr_data_o` |
| wr_data_o | output | 8 | Last byte written by the master |
| rd_req_o | output | 1 | One-cycle request for the next byte to transmit |
| rd_data_i | input | 8 | Byte to transmit, sampled the cycle after `rd_req_o` |
| busy_o | output | 1 | A transaction is open (not idle) |

## Verification
The hardest states to reach are a START that falls inside a partly shifted byte, and a repeated START just after a read address acknowledge while the block already owns the first data bit. The bench builds both by hand with a bit-level master model. In the first case it clocks half a byte, then raises SDA during SCL low and pulls it down again with SCL high. In the second case every transmitted byte has its MSB set, so the line is free for the master to form the START. Alongside these directed cases, random transactions mix the address, the direction, the length and the ACK pattern, and a one-clock SCL spike is injected mid-byte.

// File: rtl/rit_pkg.sv
package rit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_AACK = 3'd2,
        ST_WDAT = 3'd3,
        ST_WACK = 3'd4,
        ST_RDAT = 3'd5,
        ST_RACK = 3'd6,
        ST_SKIP = 3'd7
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e  state;
        logic [3:0]  bitcnt;
        logic [7:0]  shreg;
        logic        rw;
        logic        mack;
        logic        sda_oe;
        logic        wr_valid;
        logic [7:0]  wr_data;
        logic        rd_req;
    } ctl_regs_t;

    localparam int unsigned NUM_LINES = 2;
    localparam int unsigned LINE_SCL  = 0;
    localparam int unsigned LINE_SDA  = 1;

endpackage

// File: rtl/rit_line_filter.sv
module rit_line_filter #(
    parameter int unsigned FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          level;
    } flt_regs_t;

    flt_regs_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], raw_i};
        if (q.sync[1] != q.level) begin
            if (q.cnt == CW'(FILT_LEN - 1)) begin
                d.level = q.sync[1];
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync  <= 2'b11;
            q.cnt   <= '0;
            q.level <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign clean_o = q.level;
endmodule

// File: rtl/rit_bus_events.sv
module rit_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic ev_start,
    output logic ev_stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_d, scl_q;
    logic sda_d, sda_q;

    always_comb begin
        scl_d = scl;
        sda_d = sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign ev_start = scl & scl_q & sda_q & ~sda;
    assign ev_stop  = scl & scl_q & ~sda_q & sda;
    assign scl_rise = scl & ~scl_q;
    assign scl_fall = ~scl & scl_q;
endmodule

// File: rtl/rit_watchdog.sv
module rit_watchdog #(
    parameter int unsigned TIMEOUT_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic scl_edge,
    output logic expired
);
    localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign expired = active && !scl_edge && (cnt_q == LAST);

    always_comb begin
        if (!active || scl_edge || expired) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rit_ctrl.sv
module rit_ctrl
    import rit_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h42
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       expired,
    input  logic [7:0] rd_data_i,
    output logic       sda_oe_o,
    output logic       wr_valid_o,
    output logic [7:0] wr_data_o,
    output logic       rd_req_o,
    output logic       busy_o
);
    localparam logic [3:0] LAST_BIT = 4'd8;

    ctl_regs_t q, d;

    always_comb begin
        d          = q;
        d.wr_valid = 1'b0;
        d.rd_req   = 1'b0;
        if (q.rd_req) d.shreg = rd_data_i;

        case (q.state)
            ST_IDLE: ;
            ST_ADDR: begin
                if (scl_rise) begin
                    d.shreg  = {q.shreg[6:0], sda};
                    d.bitcnt = q.bitcnt + 1'b1;
                end else if (scl_fall && q.bitcnt == LAST_BIT) begin
                    if (q.shreg[7:1] == OWN_ADDR) begin
                        d.state  = ST_AACK;
                        d.sda_oe = 1'b1;
                        d.rw     = q.shreg[0];
                        d.rd_req = q.shreg[0];
                    end else begin
                        d.state = ST_SKIP;
                    end
                end
            end
            ST_AACK: begin
                if (scl_fall) begin
                    d.bitcnt = '0;
                    if (q.rw) begin
                        d.state  = ST_RDAT;
                        d.sda_oe = ~q.shreg[7];
                    end else begin
                        d.state  = ST_WDAT;
                        d.sda_oe = 1'b0;
                    end
                end
            end
            ST_WDAT: begin
                if (scl_rise) begin
                    d.shreg  = {q.shreg[6:0], sda};
                    d.bitcnt = q.bitcnt + 1'b1;
                end else if (scl_fall && q.bitcnt == LAST_BIT) begin
                    d.wr_valid = 1'b1;
                    d.wr_data  = q.shreg;
                    d.sda_oe   = 1'b1;
                    d.state    = ST_WACK;
                end
            end
            ST_WACK: begin
                if (scl_fall) begin
                    d.sda_oe = 1'b0;
                    d.bitcnt = '0;
                    d.state  = ST_WDAT;
                end
            end
            ST_RDAT: begin
                if (scl_rise) begin
                    d.bitcnt = q.bitcnt + 1'b1;
                end else if (scl_fall) begin
                    if (q.bitcnt == LAST_BIT) begin
                        d.sda_oe = 1'b0;
                        d.state  = ST_RACK;
                    end else begin
                        d.shreg  = {q.shreg[6:0], 1'b0};
                        d.sda_oe = ~q.shreg[6];
                    end
                end
            end
            ST_RACK: begin
                if (scl_rise) begin
                    d.mack   = ~sda;
                    d.rd_req = ~sda;
                end else if (scl_fall) begin
                    if (q.mack) begin
                        d.state  = ST_RDAT;
                        d.bitcnt = '0;
                        d.sda_oe = ~q.shreg[7];
                    end else begin
                        d.state = ST_SKIP;
                    end
                end
            end
            ST_SKIP: ;
            default: d.state = ST_IDLE;
        endcase

        if (expired || ev_stop) begin
            d.state  = ST_IDLE;
            d.sda_oe = 1'b0;
            d.rd_req = 1'b0;
        end
        if (ev_start) begin
            d.state  = ST_ADDR;
            d.bitcnt = '0;
            d.sda_oe = 1'b0;
            d.rd_req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state    <= ST_IDLE;
            q.bitcnt   <= '0;
            q.shreg    <= '0;
            q.rw       <= 1'b0;
            q.mack     <= 1'b0;
            q.sda_oe   <= 1'b0;
            q.wr_valid <= 1'b0;
            q.wr_data  <= '0;
            q.rd_req   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o   = q.sda_oe;
    assign wr_valid_o = q.wr_valid;
    assign wr_data_o  = q.wr_data;
    assign rd_req_o   = q.rd_req;
    assign busy_o     = (q.state != ST_IDLE);
endmodule

// File: rtl/robust_i2c_target.sv
module robust_i2c_target
    import rit_pkg::*;
#(
    parameter logic [6:0]  OWN_ADDR    = 7'h42,
    parameter int unsigned FILT_LEN    = 3,
    parameter int unsigned TIMEOUT_CYC = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic       wr_valid_o,
    output logic [7:0] wr_data_o,
    output logic       rd_req_o,
    input  logic [7:0] rd_data_i,
    output logic       busy_o
);
    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] clean_lines;
    logic scl_f, sda_f;
    logic ev_start, ev_stop, scl_rise, scl_fall;
    logic expired;

    assign raw_lines[LINE_SCL] = scl_i;
    assign raw_lines[LINE_SDA] = sda_i;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        rit_line_filter #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[i]),
            .clean_o(clean_lines[i])
        );
    end

    assign scl_f = clean_lines[LINE_SCL];
    assign sda_f = clean_lines[LINE_SDA];

    rit_bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (scl_f),
        .sda     (sda_f),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall)
    );

    rit_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (busy_o),
        .scl_edge(scl_rise | scl_fall),
        .expired (expired)
    );

    rit_ctrl #(.OWN_ADDR(OWN_ADDR)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda       (sda_f),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .expired   (expired),
        .rd_data_i (rd_data_i),
        .sda_oe_o  (sda_oe_o),
        .wr_valid_o(wr_valid_o),
        .wr_data_o (wr_data_o),
        .rd_req_o  (rd_req_o),
        .busy_o    (busy_o)
    );
endmodule

// File: rtl/rit_checks.sv
module rit_checks (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic ev_start,
    input logic ev_stop,
    input logic expired,
    input logic sda_oe_o,
    input logic busy_o,
    input logic wr_valid_o,
    input logic rd_req_o
);
    assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sda_oe_o);

    assert_drive_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_f);

    assert_wr_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);

    assert_rd_request_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    assert_start_resync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> busy_o && !sda_oe_o);

    assert_stop_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !busy_o && !sda_oe_o);

    assert_timeout_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !ev_start) |=> !busy_o && !sda_oe_o);
endmodule

bind robust_i2c_target rit_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .ev_start  (ev_start),
    .ev_stop   (ev_stop),
    .expired   (expired),
    .sda_oe_o  (sda_oe_o),
    .busy_o    (busy_o),
    .wr_valid_o(wr_valid_o),
    .rd_req_o  (rd_req_o)
);

// File: tb/robust_i2c_target_tb_top.sv
`timescale 1ns/1ps
module robust_i2c_target_tb_top;
    localparam logic [6:0] ADDR = 7'h5A;
    localparam int TMO = 600;
    localparam int Q   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe_o, wr_valid_o, rd_req_o, busy_o;
    logic [7:0] wr_data_o, rd_data_i;
    logic sda_bus;

    int total = 0, bad = 0;
    int wr_n = 0, rd_cnt = 0, r10_bad = 0;
    logic [7:0] wr_log [0:63];
    logic oe_prev = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe_o;

    function automatic logic [7:0] pat(input int k);
        logic [7:0] v;
        v = 8'(k * 59 + 17);
        return v | 8'h80;
    endfunction

    assign rd_data_i = pat(rd_cnt);

    robust_i2c_target #(.OWN_ADDR(ADDR), .FILT_LEN(3), .TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe_o(sda_oe_o), .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
        .rd_req_o(rd_req_o), .rd_data_i(rd_data_i), .busy_o(busy_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid_o) begin
                wr_log[wr_n % 64] = wr_data_o;
                wr_n++;
            end
            if (rd_req_o) rd_cnt++;
            if (sda_oe_o && !oe_prev && m_scl) r10_bad++;
            oe_prev = sda_oe_o;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2 * Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        if (glitch) begin
            m_scl = 1'b1; wq(1); m_scl = 1'b0; wq(2);
        end
        m_sda = b; wq(Q);
        m_scl = 1'b1; wq(2 * Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input int glitch_bit, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(v[i], (7 - i) == glitch_bit);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        acked = (sda_bus == 1'b0);
        wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq(Q);
            m_scl = 1'b1; wq(Q);
            v[i] = sda_bus;
            wq(Q);
            m_scl = 1'b0; wq(Q);
        end
        send_bit(!give_ack, 1'b0);
        m_sda = 1'b1;
    endtask

    initial begin
        wq(190000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] v;
        int w0, r0;
        void'($urandom(32'd4711));
        wq(5);
        // R1 reset state
        chk(!sda_oe_o && !busy_o && !wr_valid_o && !rd_req_o, "R1 reset idle",
            {sda_oe_o, busy_o, wr_valid_o, rd_req_o}, 0);
        rst_n = 1'b1; wq(10);
        chk(!busy_o && !sda_oe_o, "R1 idle after release", {busy_o, sda_oe_o}, 0);

        // R2 R3 two-byte write to own address
        w0 = wr_n;
        bus_start();
        send_byte({ADDR, 1'b0}, -1, ack);
        chk(ack, "R2 own address acked", ack, 1);
        send_byte(8'hC3, -1, ack);
        chk(ack, "R3 data acked", ack, 1);
        send_byte(8'h1E, -1, ack);
        bus_stop();
        chk(wr_n == w0 + 2, "R3 strobe count", wr_n - w0, 2);
        chk(wr_log[(w0 + 1) % 64] == 8'h1E, "R3 second byte", wr_log[(w0 + 1) % 64], 8'h1E);
        chk(!busy_o, "R8 idle after stop", busy_o, 0);

        // R11 one-clock SCL spike inside a byte
        w0 = wr_n;
        bus_start();
        send_byte({ADDR, 1'b0}, -1, ack);
        send_byte(8'h6B, 3, ack);
        bus_stop();
        chk(wr_n == w0 + 1 && wr_log[w0 % 64] == 8'h6B, "R11 spike ignored", wr_log[w0 % 64], 8'h6B);

        // R6 START inside a write data byte
        w0 = wr_n;
        bus_start();
        send_byte({ADDR, 1'b0}, -1, ack);
        for (int i = 0; i < 4; i++) send_bit(i[0], 1'b0);
        bus_rstart();
        send_byte({ADDR, 1'b0}, -1, ack);
        chk(ack, "R6 address after restart acked", ack, 1);
        send_byte(8'h3C, -1, ack);
        bus_stop();
        chk(wr_n == w0 + 1, "R6 aborted byte not delivered", wr_n - w0, 1);
        chk(wr_log[w0 % 64] == 8'h3C, "R6 data after restart", wr_log[w0 % 64], 8'h3C);

        // R6 START inside the address byte
        bus_start();
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
        bus_rstart();
        send_byte({ADDR, 1'b1}, -1, ack);
        chk(ack, "R6 restart inside address", ack, 1);
        bus_stop();

        // R7 two read address matches with no data in between
        bus_start();
        send_byte({ADDR, 1'b1}, -1, ack);
        chk(ack, "R7 first read address", ack, 1);
        bus_rstart();
        r0 = rd_cnt;
        send_byte({ADDR, 1'b1}, -1, ack);
        chk(ack, "R7 second read address acked", ack, 1);
        chk(rd_cnt == r0 + 1, "R7 request after second match", rd_cnt - r0, 1);
        recv_byte(1'b0, v);
        chk(v == pat(r0 + 1), "R7 read data", v, pat(r0 + 1));
        wq(2 * Q);
        chk(rd_cnt == r0 + 1 && busy_o && !sda_oe_o, "R5 nack releases, stays busy",
            {busy_o, sda_oe_o}, 2);
        bus_stop();
        chk(!busy_o, "R8 idle after read stop", busy_o, 0);

        // R8 STOP inside a byte
        bus_start();
        send_byte({ADDR, 1'b0}, -1, ack);
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
        bus_stop();
        chk(!busy_o && !sda_oe_o, "R8 stop mid byte", busy_o, 0);

        // R9 stall while holding the address ACK
        bus_start();
        for (int i = 7; i >= 1; i--) send_bit(ADDR[i-1], 1'b0);
        send_bit(1'b0, 1'b0);
        m_sda = 1'b1; wq(Q);
        chk(sda_oe_o && busy_o, "R2 ack driven before stall", sda_oe_o, 1);
        wq(TMO - 100);
        chk(sda_oe_o && busy_o, "R9 not yet expired", busy_o, 1);
        wq(200);
        chk(!sda_oe_o && !busy_o, "R9 timeout to idle", {busy_o, sda_oe_o}, 0);
        m_scl = 1'b1; wq(2 * Q);

        // R2 foreign address: no ack, no strobe
        w0 = wr_n;
        bus_start();
        send_byte({ADDR ^ 7'h11, 1'b0}, -1, ack);
        chk(!ack, "R2 foreign address not acked", ack, 0);
        send_byte(8'h99, -1, ack);
        chk(!ack && wr_n == w0, "R2 foreign data ignored", wr_n - w0, 0);
        bus_stop();

        // random mix
        for (int t = 0; t < 16; t++) begin
            bit match, rd;
            int len;
            logic [6:0] a;
            match = ($urandom % 3) != 0;
            rd    = $urandom % 2;
            len   = 1 + ($urandom % 3);
            a     = match ? ADDR : (ADDR ^ 7'(1 + ($urandom % 127)));
            w0 = wr_n;
            r0 = rd_cnt;
            bus_start();
            send_byte({a, rd}, -1, ack);
            chk(ack == match, "R2 random address", ack, match);
            if (match && rd) begin
                for (int j = 0; j < len; j++) begin
                    logic [7:0] e;
                    e = pat(r0 + 1 + j);
                    recv_byte(j != len - 1, v);
                    chk(v == e, "R4 random read byte", v, e);
                end
                wq(2 * Q);
                chk(rd_cnt == r0 + len, "R5 no request after nack", rd_cnt - r0, len);
            end else begin
                logic [7:0] bytes [0:2];
                for (int j = 0; j < len; j++) begin
                    bytes[j] = 8'($urandom);
                    send_byte(bytes[j], -1, ack);
                end
                if (match) begin
                    chk(wr_n == w0 + len, "R3 random write count", wr_n - w0, len);
                    chk(wr_log[(w0 + len - 1) % 64] == bytes[len - 1], "R3 random write data",
                        wr_log[(w0 + len - 1) % 64], bytes[len - 1]);
                end else begin
                    chk(wr_n == w0, "R2 random foreign ignored", wr_n - w0, 0);
                end
            end
            bus_stop();
            chk(!busy_o, "R8 random stop", busy_o, 0);
        end

        chk(r10_bad == 0, "R10 drive only while SCL low", r10_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule